// File: doc/BRIEF.md
# Timer/PWM Generator with Dead-Band and Kill

A 16-bit up-counter that doubles as a PWM source. While `run` is high the counter advances once per clock. When it reaches the active period it either wraps to zero and reloads its shadowed settings, or freezes and flags `stopped`. The mode depends on a control bit. A rising edge on the capture event input copies the running count into a capture register. The edge passes through a two-flop synchronizer first.

The raw PWM level is high while the count is below the active compare value. That level and its inverse each pass through a dead-band stage. The stage holds back a rising edge by a programmed number of clocks and lets a falling edge through at once. The result is a true output and a complementary output that are never high together. A kill input overrides both outputs combinationally with programmed safe levels. Once kill has been seen, the override stays in force until kill is low and a period boundary (a reload or a restart) is reached.

Settings arrive through a plain parallel write port. Every write is taken in the cycle it is presented. There is no back-pressure, so the port has no valid/ready pair. The capture value and the outputs are plain levels.

Top module: `pwm_timer`

## Requirements
- R1: Writes select the register by `wr_addr`: 0 = control (bit 0 stop mode, bit 1 kill level of the true output, bit 2 kill level of the complementary output), 1 = period, 2 = compare, 3 = dead-band clocks (low 8 bits). A control write restarts the counter: the count goes to 0, the period and compare shadows become active, and `stopped` clears, all at the same clock edge.
- R2: While `run` is high and the counter is not stopped, the count rises by one per clock. While `run` is low, the count holds.
- R3: In reload mode (stop bit 0), a count equal to the active period becomes 0 at the next edge, and the shadows become active at that edge.
- R4: In stop mode (stop bit 1), a count equal to the active period stays there and `stopped` goes high, until the next control write.
- R5: Period and compare writes change only the shadows. The count sequence and the outputs keep using the old values until the next reload or restart.
- R6: The raw PWM level is 1 while count < active compare. A compare of 0 gives a constant 0. A compare above the period gives a constant 1.
- R7: `pwm_true` follows the raw level and `pwm_comp` follows its inverse, each through one register. An output rises only after its source has been high for dead-band+1 consecutive clocks. It falls one clock after its source falls. The two are never high together.
- R8: While `kill_in` is high, `pwm_true` and `pwm_comp` equal the programmed kill levels in the same cycle, with no clock edge needed.
- R9: After `kill_in` falls, the kill levels stay on the outputs until the next period boundary.
- R10: `cap_evt` is synchronized by two flops. On its detected rising edge, `cap_out` takes the count present two clock edges after the input rose. A level held high captures only once.
- R11: During reset the count, capture value, both outputs and `stopped` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| cap_evt | input | 1 | Asynchronous capture event |
| kill_in | input | 1 | Output kill request |
| cnt_out | output | 16 | Current count |
| cap_out | output | 16 | Last captured count |
| pwm_true | output | 1 | True PWM output |
| pwm_comp | output | 1 | Complementary PWM output |
| stopped | output | 1 | Counter halted at period (stop mode) |

## Verification
The main function is driven with randomly drawn period, compare and dead-band triples. These are mixed with forced cases at compare 0 and compare above the period. Comparing every cycle against a bench model of the count sequence and a run-length rule for the outputs separates errors in wrap position, in the compare boundary (< against <=), and in how many clocks a rising edge is delayed. Directed runs then test four more behaviours: a period write made mid-cycle, which exposes shadows that load too early; a kill released before the boundary, which exposes a kill that is not held; a capture input that stays high, which exposes a missing edge detector; and stop mode, which separates freezing from wrapping.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_PERIOD  = 2'd1,
    ADDR_COMPARE = 2'd2,
    ADDR_DEAD    = 2'd3
  } reg_addr_e;

  // bit 0 stop mode, bit 1 kill level true, bit 2 kill level comp
  typedef struct packed {
    logic kill_lvl_comp;
    logic kill_lvl_true;
    logic stop_mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter int               DB_W        = 8,
  parameter logic [CNT_W-1:0] RST_PERIOD  = '1,
  parameter logic [CNT_W-1:0] RST_COMPARE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] period_sh,
  output logic [CNT_W-1:0] cmp_sh,
  output logic [DB_W-1:0]  dead,
  output logic             restart
);

  reg_addr_e addr;
  assign addr    = reg_addr_e'(wr_addr);
  assign restart = wr_en && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      period_sh <= RST_PERIOD;
      cmp_sh    <= RST_COMPARE;
      dead      <= '0;
    end else if (wr_en) begin
      unique case (addr)
        ADDR_CTRL:    ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_PERIOD:  period_sh <= wr_data;
        ADDR_COMPARE: cmp_sh    <= wr_data;
        ADDR_DEAD:    dead      <= wr_data[DB_W-1:0];
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int               CNT_W       = 16,
  parameter logic [CNT_W-1:0] RST_PERIOD  = '1,
  parameter logic [CNT_W-1:0] RST_COMPARE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             stop_mode,
  input  logic [CNT_W-1:0] period_sh,
  input  logic [CNT_W-1:0] cmp_sh,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_act,
  output logic             halted,
  output logic             boundary
);

  logic [CNT_W-1:0] per_act;
  logic             at_per;
  logic             active;

  assign at_per   = (count == per_act);
  assign active   = run && !halted;
  assign boundary = restart || (active && at_per && !stop_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      per_act <= RST_PERIOD;
      cmp_act <= RST_COMPARE;
      halted  <= 1'b0;
    end else if (restart) begin
      count   <= '0;
      per_act <= period_sh;
      cmp_act <= cmp_sh;
      halted  <= 1'b0;
    end else if (active) begin
      if (at_per) begin
        if (stop_mode) begin
          halted <= 1'b1;
        end else begin
          count   <= '0;
          per_act <= period_sh;
          cmp_act <= cmp_sh;
        end
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= per_act);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart && !at_per) |=> (count == $past(count) + 1'b1));

  p_reload_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart && at_per && !stop_mode) |=> (count == '0));

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> ($stable(count) && halted));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(count));

endmodule

// File: rtl/pwm_capture.sv
module pwm_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap
);

  logic [2:0] sync_q;
  logic       rise;

  assign rise = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      cap    <= '0;
    end else begin
      sync_q <= {sync_q[1:0], evt_in};
      if (rise) cap <= count;
    end
  end

  p_cap_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(cap));

  p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [DB_W-1:0] dead,
  output logic            dout
);

  logic [DB_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      dout    <= 1'b0;
    end else if (!din) begin
      run_len <= '0;
      dout    <= 1'b0;
    end else if (run_len >= dead) begin
      dout <= 1'b1;
    end else begin
      run_len <= run_len + 1'b1;
    end
  end

  p_rise_needs_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> $past(din));

  p_fall_prompt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !din |=> !dout);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter int               DB_W        = 8,
  parameter logic [CNT_W-1:0] RST_PERIOD  = '1,
  parameter logic [CNT_W-1:0] RST_COMPARE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cap_evt,
  input  logic             kill_in,
  output logic [CNT_W-1:0] cnt_out,
  output logic [CNT_W-1:0] cap_out,
  output logic             pwm_true,
  output logic             pwm_comp,
  output logic             stopped
);

  localparam int NUM_OUT = 2;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] period_sh;
  logic [CNT_W-1:0] cmp_sh;
  logic [DB_W-1:0]  dead;
  logic             restart;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmp_act;
  logic             halted;
  logic             boundary;
  logic             raw;
  logic [NUM_OUT-1:0] db_in;
  logic [NUM_OUT-1:0] db_out;
  logic             kill_lat;
  logic             kill_act;

  pwm_regs #(
    .CNT_W(CNT_W), .DB_W(DB_W),
    .RST_PERIOD(RST_PERIOD), .RST_COMPARE(RST_COMPARE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .period_sh(period_sh),
    .cmp_sh(cmp_sh), .dead(dead), .restart(restart)
  );

  pwm_counter #(
    .CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD), .RST_COMPARE(RST_COMPARE)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .stop_mode(ctrl.stop_mode), .period_sh(period_sh), .cmp_sh(cmp_sh),
    .count(count), .cmp_act(cmp_act), .halted(halted), .boundary(boundary)
  );

  pwm_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt_in(cap_evt), .count(count), .cap(cap_out)
  );

  assign raw   = (count < cmp_act);
  assign db_in = {~raw, raw};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_db
    pwm_deadband #(.DB_W(DB_W)) u_db (
      .clk(clk), .rst_n(rst_n), .din(db_in[i]), .dead(dead), .dout(db_out[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        kill_lat <= 1'b0;
    else if (kill_in)  kill_lat <= 1'b1;
    else if (boundary) kill_lat <= 1'b0;
  end

  assign kill_act = kill_in || kill_lat;
  assign pwm_true = kill_act ? ctrl.kill_lvl_true : db_out[0];
  assign pwm_comp = kill_act ? ctrl.kill_lvl_comp : db_out[1];
  assign cnt_out  = count;
  assign stopped  = halted;

  p_kill_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_in |-> (pwm_true == ctrl.kill_lvl_true && pwm_comp == ctrl.kill_lvl_comp));

  p_kill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_in && !restart) |=> (pwm_true == $past(ctrl.kill_lvl_true)));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(db_out[0] && db_out[1]));

endmodule

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cap_evt = 1'b0;
  logic        kill_in = 1'b0;
  logic [15:0] cnt_out, cap_out;
  logic        pwm_true, pwm_comp, stopped;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_evt(cap_evt), .kill_in(kill_in),
    .cnt_out(cnt_out), .cap_out(cap_out), .pwm_true(pwm_true),
    .pwm_comp(pwm_comp), .stopped(stopped)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // control write together with run: edge between the negedges is the restart
  task automatic restart_run(input logic [2:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = {13'd0, c}; run = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit raw_at(input int k, input int p, input int c);
    return (k % (p + 1)) < c;
  endfunction

  function automatic bit run_high(input logic [15:0] h, input int d);
    logic [15:0] m;
    m = (16'd1 << (d + 1)) - 16'd1;
    return (h & m) == m;
  endfunction

  initial begin
    int seed;
    int p, c, d, kk, m1, m2, g;
    logic [15:0] hist;
    logic [15:0] v;
    seed = $urandom(32'd20240611);

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 count", 32'(cnt_out), 0);
    chk("R11 capture", 32'(cap_out), 0);
    chk("R11 true", 32'(pwm_true), 0);
    chk("R11 comp", 32'(pwm_comp), 0);
    chk("R11 stopped", 32'(stopped), 0);
    rst_n = 1'b1;

    // R2, R3, R6, R7: random period/compare/dead-band
    for (int t = 0; t < 8; t++) begin
      p = 3 + int'($urandom % 14);
      c = int'($urandom % (p + 3));
      d = int'($urandom % 5);
      if (t == 0) c = 0;
      if (t == 1) c = p + 1;
      if (t == 2) d = 0;
      run = 1'b0;
      wr(2'd1, 16'(p));
      wr(2'd2, 16'(c));
      wr(2'd3, 16'(d));
      restart_run(3'b000);
      chk("R1 restart count", 32'(cnt_out), 0);
      hist = '0;
      kk = 4 * (p + 1) + 10;
      for (int k = 1; k <= kk; k++) begin
        @(negedge clk);
        chk("R2,R3 count", 32'(cnt_out), 32'(k % (p + 1)));
        hist = {hist[14:0], raw_at(k - 1, p, c)};
        if (k > p + d + 3) begin
          chk("R6,R7 true", 32'(pwm_true), 32'(run_high(hist, d)));
          chk("R6,R7 comp", 32'(pwm_comp), 32'(run_high(~hist, d)));
        end
        chk("R7 overlap", 32'(pwm_true & pwm_comp), 0);
      end
    end

    // R4: stop mode
    run = 1'b0;
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd3);
    restart_run(3'b001);
    repeat (10) @(negedge clk);
    chk("R4 frozen at period", 32'(cnt_out), 5);
    chk("R4 stopped flag", 32'(stopped), 1);
    repeat (3) @(negedge clk);
    chk("R4 still frozen", 32'(cnt_out), 5);
    restart_run(3'b000);
    chk("R1 restart clears count", 32'(cnt_out), 0);
    chk("R1 restart clears stopped", 32'(stopped), 0);

    // R10: capture with frozen count, level held, then running
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    v = cnt_out;
    cap_evt = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 hold while idle", 32'(cnt_out), 32'(v));
    chk("R10 frozen capture", 32'(cap_out), 32'(v));
    run = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R10 held level no recapture", 32'(cap_out), 32'(v));
    cap_evt = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    cap_evt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    v = cnt_out;
    @(negedge clk);
    chk("R10 running capture", 32'(cap_out), 32'(v));
    cap_evt = 1'b0;

    // R5: shadow registers
    run = 1'b0;
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd20);
    wr(2'd3, 16'd0);
    restart_run(3'b000);
    repeat (3) @(negedge clk);
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd0);
    m1 = int'(cnt_out);
    g = 0;
    while (cnt_out != 0 && g < 40) begin
      if (int'(cnt_out) > m1) m1 = int'(cnt_out);
      chk("R5 old compare kept", 32'(pwm_true), 1);
      @(negedge clk);
      g++;
    end
    chk("R5 old period kept", 32'(m1), 9);
    m2 = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (int'(cnt_out) > m2) m2 = int'(cnt_out);
    end
    chk("R5 new period after reload", 32'(m2), 4);
    chk("R5 new compare after reload", 32'(pwm_true), 0);

    // R8, R9: kill force and hold to boundary
    run = 1'b0;
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd10);
    wr(2'd3, 16'd0);
    restart_run(3'b100);
    repeat (4) @(negedge clk);
    chk("R7 baseline true", 32'(pwm_true), 1);
    chk("R7 baseline comp", 32'(pwm_comp), 0);
    kill_in = 1'b1;
    #1;
    chk("R8 kill true immediate", 32'(pwm_true), 0);
    chk("R8 kill comp immediate", 32'(pwm_comp), 1);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (cnt_out != 2 && g < 40);
    kill_in = 1'b0;
    #1;
    chk("R9 forced after release", 32'(pwm_true), 0);
    g = 0;
    while (cnt_out != 0 && g < 40) begin
      chk("R9 forced until boundary", 32'({pwm_true, pwm_comp}), 32'b01);
      @(negedge clk);
      g++;
    end
    chk("R9 released at boundary", 32'({pwm_true, pwm_comp}), 32'b10);

    run = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule